// File: doc/BRIEF.md
# Character Bank and Nametable Mirroring Unit

This unit sits on the video side of a cartridge banking controller. It holds eight 1 KB character bank registers and a two-bit mirroring mode register. All nine are loaded over the shared command/parameter register bus: a write strobe plus a command index and a data byte. From the video address it forms the external character memory address. It also produces the single nametable RAM address line, which picks one of two 1 KB nametables.

The video address bits 12:10 pick one of eight slots. The slot's bank number becomes the upper part of the character address, and the low ten address bits pass straight through. The fitted character memory may be smaller than the 256 KB an 8-bit bank can reach. A parameter gives the number of bank bits actually fitted, and the unused upper bits are forced to zero. The mirroring register picks vertical, horizontal or one of two single-screen arrangements. Its value after reset comes from a strap input, so the board wiring sets the initial layout.

Register writes take effect on the clock edge that samples the strobe. Both outputs are combinational from the registers and the video address. The character and nametable memories are outside the unit.

Top module: `chr_bank_mirror`

## Requirements
- R1: While reset is held low at a clock edge, slot n is loaded with bank number n (n = 0..7), giving an identity map of the first 8 KB.
- R2: While reset is held low at a clock edge, the mirroring mode register is loaded from `mirror_strap`.
- R3: A write with command index n in 0..7 loads the slot-n bank register with `cfg_data`. The new value is visible on `chr_addr` from the clock edge that samples the write.
- R4: `chr_addr` equals {bank of slot ppu_addr[12:10], ppu_addr[9:0]}, with ten offset bits in the low positions.
- R5: Bank bits at and above position FIT_BITS (default 7, that is 128 KB fitted) read as zero in `chr_addr`, whatever value was written.
- R6: A write with command index 12 loads the mirroring mode from `cfg_data[1:0]`; `cfg_data[7:2]` has no effect.
- R7: `ntbl_sel` is ppu_addr[10] in mode 0 (vertical), ppu_addr[11] in mode 1 (horizontal), 0 in mode 2 and 1 in mode 3.
- R8: Writes with command index 8 to 11 or 13 to 15 change neither any bank register nor the mirroring mode.
- R9: No register changes in a cycle where `cfg_we` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mirror_strap | input | 2 | Mirroring mode loaded during reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_cmd | input | 4 | Command index of the write |
| cfg_data | input | BANK_W (8) | Parameter data of the write |
| ppu_addr | input | 13 | Video address bits 12:0 |
| chr_addr | output | BANK_W+10 (18) | Character memory address |
| ntbl_sel | output | 1 | Nametable RAM select line |

## Verification
A register write is driven on a falling edge. The rising edge that follows loads it, so any effect on `chr_addr` or `ntbl_sel` is due on that edge, with no further pipeline stage. The bench waits for the next falling edge and then a further nanosecond before sampling. At that point the new video address has settled through the purely combinational translation and the registers are stable. Every random write is followed by at least one random video address. Both outputs are compared with a bench model, which covers the window straight after each write, including ignored commands and reserved data bits.

// File: rtl/cbm_pkg.sv
`timescale 1ns/1ps
package cbm_pkg;
   typedef enum logic [1:0] {
      MIR_VERT   = 2'd0,
      MIR_HORZ   = 2'd1,
      MIR_ONE_LO = 2'd2,
      MIR_ONE_HI = 2'd3
   } mir_mode_t;

   localparam int unsigned SLOT_COUNT  = 8;
   localparam int unsigned SLOT_SEL_W  = $clog2(SLOT_COUNT);
   localparam int unsigned SLOT_OFS_W  = 10;
   localparam int unsigned CMD_W       = 4;
   localparam logic [CMD_W-1:0] CMD_MIRROR = 4'hC;
endpackage

// File: rtl/cbm_bank_regs.sv
`timescale 1ns/1ps
module cbm_bank_regs
   import cbm_pkg::*;
#(
   parameter int unsigned BANK_W = 8
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic                                we,
   input  logic [CMD_W-1:0]                    cmd,
   input  logic [BANK_W-1:0]                   data,
   output logic [SLOT_COUNT-1:0][BANK_W-1:0]   bank_q
);
   generate
      if (BANK_W < SLOT_SEL_W) begin : g_bad_w
         $error("cbm_bank_regs: BANK_W too small for identity reset map");
      end
      if ((1 << CMD_W) <= SLOT_COUNT) begin : g_bad_cmd
         $error("cbm_bank_regs: command space cannot hold all slots");
      end
   endgenerate

   generate
      for (genvar s = 0; s < SLOT_COUNT; s++) begin : g_slot
         localparam logic [CMD_W-1:0]  MY_CMD   = CMD_W'(s);
         localparam logic [BANK_W-1:0] RST_BANK = BANK_W'(s);
         logic hit;
         assign hit = we && (cmd == MY_CMD);

         always_ff @(posedge clk) begin
            if (!rst_n)   bank_q[s] <= RST_BANK;
            else if (hit) bank_q[s] <= data;
         end

         // R3
         slot_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (we && cmd == MY_CMD) |=> (bank_q[s] == $past(data)));
      end
   endgenerate

   // R8
   bank_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (we && cmd >= CMD_W'(SLOT_COUNT)) |=> $stable(bank_q));

   // R9
   bank_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!we) |=> $stable(bank_q));
endmodule

// File: rtl/cbm_mirror_ctl.sv
`timescale 1ns/1ps
module cbm_mirror_ctl
   import cbm_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       strap,
   input  logic             we,
   input  logic [CMD_W-1:0] cmd,
   input  logic [1:0]       data_lo,
   input  logic             a10,
   input  logic             a11,
   output mir_mode_t        mode_q,
   output logic             sel
);
   logic load;
   assign load = we && (cmd == CMD_MIRROR);

   always_ff @(posedge clk) begin
      if (!rst_n)    mode_q <= mir_mode_t'(strap);
      else if (load) mode_q <= mir_mode_t'(data_lo);
   end

   always_comb begin
      unique case (mode_q)
         MIR_VERT:   sel = a10;
         MIR_HORZ:   sel = a11;
         MIR_ONE_LO: sel = 1'b0;
         MIR_ONE_HI: sel = 1'b1;
         default:    sel = 1'b0;
      endcase
   end

   // R6
   mode_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (we && cmd == CMD_MIRROR) |=> (mode_q == $past(data_lo)));

   // R8
   mode_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (we && cmd != CMD_MIRROR) |=> $stable(mode_q));

   // R9
   mode_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!we) |=> $stable(mode_q));
endmodule

// File: rtl/cbm_chr_xlate.sv
`timescale 1ns/1ps
module cbm_chr_xlate
   import cbm_pkg::*;
#(
   parameter int unsigned BANK_W = 8,
   parameter int unsigned FIT_W  = 7,
   localparam int unsigned OUT_W = BANK_W + SLOT_OFS_W
) (
   input  logic [SLOT_COUNT-1:0][BANK_W-1:0]  bank_q,
   input  logic [SLOT_SEL_W+SLOT_OFS_W-1:0]   vaddr,
   output logic [OUT_W-1:0]                   chr_addr
);
   logic [SLOT_SEL_W-1:0] slot;
   logic [BANK_W-1:0]     raw_bank;
   logic [BANK_W-1:0]     fit_bank;

   assign slot     = vaddr[SLOT_OFS_W +: SLOT_SEL_W];
   assign raw_bank = bank_q[slot];

   generate
      if (FIT_W == 0 || FIT_W > BANK_W) begin : g_bad_fit
         $error("cbm_chr_xlate: FIT_W must be in 1..BANK_W");
      end
      if (FIT_W == BANK_W) begin : g_full
         assign fit_bank = raw_bank;
      end else begin : g_masked
         localparam logic [BANK_W-1:0] FIT_MASK = BANK_W'((64'd1 << FIT_W) - 64'd1);
         assign fit_bank = raw_bank & FIT_MASK;
      end
   endgenerate

   assign chr_addr = {fit_bank, vaddr[SLOT_OFS_W-1:0]};
endmodule

// File: rtl/chr_bank_mirror.sv
`timescale 1ns/1ps
module chr_bank_mirror
   import cbm_pkg::*;
#(
   parameter int unsigned BANK_W   = 8,
   parameter int unsigned FIT_BITS = 7,
   localparam int unsigned CHR_AW  = BANK_W + SLOT_OFS_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [1:0]         mirror_strap,
   input  logic               cfg_we,
   input  logic [3:0]         cfg_cmd,
   input  logic [BANK_W-1:0]  cfg_data,
   input  logic [12:0]        ppu_addr,
   output logic [CHR_AW-1:0]  chr_addr,
   output logic               ntbl_sel
);
   logic [SLOT_COUNT-1:0][BANK_W-1:0] bank_q;
   mir_mode_t                         mode_q;

   cbm_bank_regs #(.BANK_W(BANK_W)) u_banks (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (cfg_we),
      .cmd    (cfg_cmd),
      .data   (cfg_data),
      .bank_q (bank_q)
   );

   cbm_mirror_ctl u_mirror (
      .clk     (clk),
      .rst_n   (rst_n),
      .strap   (mirror_strap),
      .we      (cfg_we),
      .cmd     (cfg_cmd),
      .data_lo (cfg_data[1:0]),
      .a10     (ppu_addr[10]),
      .a11     (ppu_addr[11]),
      .mode_q  (mode_q),
      .sel     (ntbl_sel)
   );

   cbm_chr_xlate #(.BANK_W(BANK_W), .FIT_W(FIT_BITS)) u_xlate (
      .bank_q   (bank_q),
      .vaddr    (ppu_addr),
      .chr_addr (chr_addr)
   );

   // R4
   offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      chr_addr[SLOT_OFS_W-1:0] == ppu_addr[SLOT_OFS_W-1:0]);

   // R4
   slot_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
      chr_addr[CHR_AW-1:SLOT_OFS_W + FIT_BITS - 1 + 1 - FIT_BITS] ==
      (bank_q[ppu_addr[12:10]] & BANK_W'((64'd1 << FIT_BITS) - 64'd1)));

   // R7
   vert_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == MIR_VERT) |-> (ntbl_sel == ppu_addr[10]));

   // R7
   horz_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == MIR_HORZ) |-> (ntbl_sel == ppu_addr[11]));

   // R7
   single_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == MIR_ONE_LO || mode_q == MIR_ONE_HI) |-> (ntbl_sel == mode_q[0]));
endmodule

// File: tb/chr_bank_mirror_tb.sv
`timescale 1ns/1ps
module chr_bank_mirror_tb;
   localparam int FIT = 7;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  mirror_strap = 2'd1;
   logic        cfg_we = 1'b0;
   logic [3:0]  cfg_cmd = 4'd0;
   logic [7:0]  cfg_data = 8'd0;
   logic [12:0] ppu_addr = 13'd0;
   logic [17:0] chr_addr;
   logic        ntbl_sel;

   int checks = 0;
   int fails  = 0;
   logic [7:0] m_bank [8];
   logic [1:0] m_mode;

   always #4 clk = ~clk;

   chr_bank_mirror #(.BANK_W(8), .FIT_BITS(FIT)) u_dut (
      .clk(clk), .rst_n(rst_n), .mirror_strap(mirror_strap),
      .cfg_we(cfg_we), .cfg_cmd(cfg_cmd), .cfg_data(cfg_data),
      .ppu_addr(ppu_addr), .chr_addr(chr_addr), .ntbl_sel(ntbl_sel)
   );

   function automatic logic [17:0] exp_chr(input logic [12:0] a);
      logic [7:0] b;
      b = m_bank[a[12:10]] & 8'h7F;
      return {b, a[9:0]};
   endfunction

   function automatic logic exp_sel(input logic [12:0] a);
      case (m_mode)
         2'd0: return a[10];
         2'd1: return a[11];
         2'd2: return 1'b0;
         default: return 1'b1;
      endcase
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic do_reset(input logic [1:0] strap);
      @(negedge clk);
      rst_n = 1'b0;
      mirror_strap = strap;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      for (int i = 0; i < 8; i++) m_bank[i] = 8'(i);
      m_mode = strap;
   endtask

   task automatic wr(input logic [3:0] c, input logic [7:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_cmd = c; cfg_data = d;
      @(negedge clk);
      cfg_we = 1'b0;
      if (c < 4'd8) m_bank[c[2:0]] = d;
      else if (c == 4'hC) m_mode = d[1:0];
   endtask

   task automatic probe(input string req, input logic [12:0] a);
      ppu_addr = a;
      #1;
      chk(req, 32'(chr_addr), 32'(exp_chr(a)));
      chk(req, 32'(ntbl_sel), 32'(exp_sel(a)));
   endtask

   initial begin : watchdog
      #(200000 * 8);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin : stim
      void'($urandom(32'd20240611));
      do_reset(2'd1);
      // R1: identity map after reset
      for (int s = 0; s < 8; s++) probe("R1", 13'(s * 1024 + 37));
      // R2: strap value 1 -> horizontal, ntbl_sel follows bit 11
      probe("R2", 13'h0800);
      probe("R2", 13'h0400);
      // R3/R4: load slot 5 and read through it
      wr(4'd5, 8'h3A);
      probe("R3", {3'd5, 10'h155});
      probe("R4", {3'd4, 10'h3FF});
      // R5: bit 7 of bank masked off
      wr(4'd0, 8'hFF);
      #1; ppu_addr = 13'h0000; #1;
      chk("R5", 32'(chr_addr[17]), 32'd0);
      probe("R5", 13'h0123);
      // R6: reserved data bits ignored
      wr(4'hC, 8'hFC);
      probe("R6", 13'h0C00);
      for (int m = 0; m < 4; m++) begin
         wr(4'hC, 8'(m));
         probe("R7", 13'h0400);
         probe("R7", 13'h0800);
         probe("R7", 13'h0000);
      end
      // R8: ignored commands
      for (int c = 8; c < 16; c++) begin
         if (c != 12) begin
            wr(4'(c), 8'hA5);
            for (int s = 0; s < 8; s++) probe("R8", 13'(s * 1024 + c));
         end
      end
      // R9: data present with strobe low
      @(negedge clk);
      cfg_cmd = 4'd2; cfg_data = 8'h11;
      repeat (2) @(negedge clk);
      probe("R9", 13'h0800);
      // R2: reset with each single-screen strap
      do_reset(2'd3);
      probe("R2", 13'h0000);
      do_reset(2'd2);
      probe("R2", 13'h0C00);
      probe("R1", 13'h1FFF);
      // random mix
      for (int i = 0; i < 400; i++) begin
         wr(4'($urandom % 16), 8'($urandom));
         probe("R3", 13'($urandom));
         probe("R4", 13'($urandom));
      end
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule